// File: doc/BRIEF.md
# I/O interrupt redirection controller

This block sits in an I/O bridge and turns up to eight interrupt input lines into posted message writes toward a processor. Software configures it through three memory-mapped registers. A select register picks an entry in an indexed table, a window register reads or writes that entry, and an end-of-interrupt (EOI) register retires delivered vectors. Each input owns two table words. The control word holds a mask bit, trigger and polarity settings, and a 6-bit vector. The destination word holds a swizzled target address.

On a rising edge of an enabled input, the block records a pending bit and queues one message write. The write goes to the unswizzled 64-bit destination and carries the vector. The pending bit re-arms when the input deasserts, when a masked rise occurs, or on an EOI whose vector matches. The message port uses a valid/ready handshake. A request stays held until it is accepted, and later requests wait behind it in input-index order.

Top module: `irq_redirect`

## Requirements
- R1: After reset the pending vector is zero and no message is requested. The control word of input i (table index 0x10+2*i) reads 0x1A000 + (i+2), which means masked (bit 16), level (bit 15), active-low (bit 13) and vector i+2. Every destination word (index 0x11+2*i) reads 0xA0FF0000.
- R2: A write to offset 0x800 sets the select register and a read returns it. A window access at offset 0x810 reads or writes the table word chosen by select.
- R3: Table index 1 reads as the constant 0x00200001, which is the table size 32 in bits 31:16 and 1 in the low bits. Window writes to index 1 have no effect.
- R4: When select is 32 or more, a window read returns 0xFFFFFFFF with reg_err high, and a window write has no effect and raises reg_err. Any access to an undecoded offset also raises reg_err.
- R5: A rising edge on an unmasked input sets pending bit (vector AND 7). If that bit was clear, the rise issues one message. The message address is {32'hFFFFFFFF, ((d<<4)&0x0FF00000) | ((d>>12)&0x000FF000) | 0xF0000000}, where d is the destination word. The message data holds the vector in bits 29:24, with all other bits zero.
- R6: A rising edge on a masked input issues no message and clears pending bit (vector AND 7).
- R7: An input held high issues no further message. Its deassertion clears its pending bit, and a following rise issues a new message.
- R8: A write to the EOI register at offset 0x840 takes the written value AND 63. It clears pending bit i for every input i whose vector equals that value, and it leaves all other bits unchanged.
- R9: While msg_ready is low, msg_valid, msg_addr and msg_data hold. When several inputs fire together, their messages leave one at a time, lowest input index first.
- R10: A rise on an unmasked input whose pending bit is already set issues no message and leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW (12) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational with reg_rd |
| reg_err | output | 1 | Access went to an unmapped location |
| irq_in | input | NUM_IN (8) | Interrupt inputs, high means asserted |
| pend | output | NUM_IN (8) | Pending bit vector |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload, big-endian vector |

## Verification
The bench builds the block with its defaults: eight inputs, a 32-word table and a 12-bit offset. With eight inputs the pending index is three bits wide, so different vectors can share a pending bit, which allows the shared-bit masked-clear and already-pending cases to be driven. The 32-word table puts the select boundary at 31/32 within easy reach. The inputs occupy indices 0x10 to 0x1F, which fills the table exactly.

// File: rtl/irq_redirect.sv
module irq_redirect #(
  parameter int NUM_IN = 8,
  parameter int TBL_WORDS = 32,
  parameter int AW = 12,
  parameter logic [31:0] DEF_CPU = 32'hFFFA0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic [NUM_IN-1:0] irq_in,
  output logic [NUM_IN-1:0] pend,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int IW = $clog2(NUM_IN);
  localparam int TW = $clog2(TBL_WORDS);
  localparam int BASE = 16;
  localparam logic [AW-1:0] OFF_SEL = AW'(12'h800);
  localparam logic [AW-1:0] OFF_WIN = AW'(12'h810);
  localparam logic [AW-1:0] OFF_EOI = AW'(12'h840);
  localparam logic [31:0] VERSION = (32'(TBL_WORDS) << 16) | 32'd1;
  localparam logic [31:0] DEF_SWZ = ((DEF_CPU & 32'h0ff00000) >> 4) |
                                    ((DEF_CPU & 32'h000ff000) << 12);

  function automatic logic [31:0] init_word(int k);
    if (k >= BASE && k < BASE + 2*NUM_IN)
      return (k % 2 == 0) ? (32'h1A000 + 32'((k - BASE)/2 + 2)) : DEF_SWZ;
    return 32'd0;
  endfunction

  function automatic logic [31:0] unswz(logic [31:0] d);
    return ((d << 4) & 32'h0ff00000) | ((d >> 12) & 32'h000ff000) | 32'hf0000000;
  endfunction

  logic [31:0] sel_q;
  logic [31:0] tbl [TBL_WORDS];
  logic [NUM_IN-1:0] irq_q, pend_q, pend_d, need_q, fire;
  logic [IW-1:0] pick;
  logic found, rd_bad;

  wire hit_sel = reg_addr == OFF_SEL;
  wire hit_win = reg_addr == OFF_WIN;
  wire hit_eoi = reg_addr == OFF_EOI;
  wire sel_ok  = sel_q < 32'(TBL_WORDS);
  wire [TW-1:0] sel_idx = sel_q[TW-1:0];
  wire win_wr  = reg_wr && hit_win && sel_ok && sel_q != 32'd1;
  wire eoi_wr  = reg_wr && hit_eoi;
  wire launch  = found && (!msg_valid || msg_ready);

  assign pend = pend_q;

  always_comb begin
    reg_rdata = '1;
    rd_bad = 1'b0;
    if (hit_sel) reg_rdata = sel_q;
    else if (hit_win && sel_q == 32'd1) reg_rdata = VERSION;
    else if (hit_win && sel_ok) reg_rdata = tbl[sel_idx];
    else rd_bad = 1'b1;
  end

  assign reg_err = (reg_rd && rd_bad) ||
                   (reg_wr && !(hit_sel || hit_eoi || (hit_win && sel_ok)));

  always_comb begin
    logic [31:0] ctl;
    logic [IW-1:0] b;
    pend_d = pend_q;
    fire = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      ctl = tbl[BASE + 2*i];
      b = ctl[IW-1:0];
      if (irq_in[i] && !irq_q[i]) begin
        if (!ctl[16]) begin
          if (!pend_d[b]) fire[i] = 1'b1;
          pend_d[b] = 1'b1;
        end else begin
          pend_d[b] = 1'b0;
        end
      end else if (!irq_in[i] && irq_q[i]) begin
        pend_d[b] = 1'b0;
      end
    end
    if (eoi_wr)
      for (int i = 0; i < NUM_IN; i++)
        if (tbl[BASE + 2*i][5:0] == reg_wdata[5:0]) pend_d[i] = 1'b0;
  end

  always_comb begin
    found = 1'b0;
    pick = '0;
    for (int i = NUM_IN - 1; i >= 0; i--)
      if (need_q[i]) begin
        found = 1'b1;
        pick = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int k = 0; k < TBL_WORDS; k++) tbl[k] <= init_word(k);
      irq_q <= '0;
      pend_q <= '0;
      need_q <= '0;
      msg_valid <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      if (reg_wr && hit_sel) sel_q <= reg_wdata;
      if (win_wr) tbl[sel_idx] <= reg_wdata;
      irq_q <= irq_in;
      pend_q <= pend_d;
      need_q <= (need_q & ~(launch ? (NUM_IN'(1) << pick) : '0)) | fire;
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (launch) begin
        msg_valid <= 1'b1;
        msg_addr <= {32'hFFFFFFFF, unswz(tbl[BASE + 2*int'(pick) + 1])};
        msg_data <= {2'b00, tbl[BASE + 2*int'(pick)][5:0], 24'd0};
      end
    end
  end
endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
  parameter int AW = 12,
  parameter int TBL_WORDS = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          reg_err,
  input logic [31:0]   sel_q,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [63:0]   msg_addr,
  input logic [31:0]   msg_data
);
  localparam logic [AW-1:0] WIN = AW'(12'h810);

  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  assert_msg_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[63:28] == '1 && msg_addr[11:0] == 12'd0 &&
                  msg_data[31:30] == 2'b00 && msg_data[23:0] == 24'd0);

  assert_unmapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == WIN && sel_q >= 32'(TBL_WORDS) |-> reg_err && reg_rdata == '1);

  assert_version_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == WIN && sel_q == 32'd1 |->
      !reg_err && reg_rdata == ((32'(TBL_WORDS) << 16) | 32'd1));
endmodule

bind irq_redirect irq_redirect_chk #(.AW(AW), .TBL_WORDS(TBL_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .reg_err(reg_err), .sel_q(sel_q),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data)
);

// File: tb/irq_redirect_bench.sv
module irq_redirect_bench;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, msg_ready = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_err, msg_valid;
  logic [7:0] irq_in = 0, pend;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_redirect u_irq_redirect (.*);

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; irq_in = 0; msg_ready = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wr_err(input logic [11:0] a, input logic [31:0] d, output logic e);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; #1 e = reg_err;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata; e = reg_err;
    reg_rd = 0;
  endtask

  task automatic tbl_wr(input int idx, input logic [31:0] d);
    wr(12'h800, idx); wr(12'h810, d);
  endtask

  task automatic tbl_rd(input int idx, output logic [31:0] d);
    logic e;
    wr(12'h800, idx); rd(12'h810, d, e);
  endtask

  task automatic expect_msg(input logic [63:0] a, input logic [31:0] d, input string tag);
    int n = 0;
    while (!msg_valid && n < 8) begin @(negedge clk); n++; end
    check(msg_valid, tag, 64'(msg_valid), 64'd1);
    check(msg_addr == a, tag, msg_addr, a);
    check(msg_data == d, tag, 64'(msg_data), 64'(d));
    msg_ready = 1; @(negedge clk); msg_ready = 0;
  endtask

  task automatic expect_none(input string tag);
    logic seen = 0;
    for (int n = 0; n < 6; n++) begin @(negedge clk); seen |= msg_valid; end
    check(!seen, tag, 64'(seen), 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    do_reset(); @(negedge clk);
    check(pend == 0, "R1 pend", 64'(pend), 0);
    check(!msg_valid, "R1 msg_valid", 64'(msg_valid), 0);
    for (int i = 0; i < 8; i += 7) begin
      tbl_rd(16 + 2*i, d); check(d == 32'h1A000 + i + 2, "R1 ctl", 64'(d), 64'(32'h1A000 + i + 2));
      tbl_rd(17 + 2*i, d); check(d == 32'hA0FF0000, "R1 dest", 64'(d), 64'hA0FF0000);
    end
    wr(12'h800, 32'h17); rd(12'h800, d, e);
    check(d == 32'h17 && !e, "R2 select readback", 64'(d), 64'h17);
  endtask

  task automatic t_window();
    logic [31:0] d; logic e;
    do_reset();
    tbl_wr(5, 32'h12345678); tbl_rd(5, d);
    check(d == 32'h12345678, "R2 window", 64'(d), 64'h12345678);
    tbl_rd(1, d); check(d == 32'h00200001, "R3 version", 64'(d), 64'h00200001);
    tbl_wr(1, 32'h0); tbl_rd(1, d);
    check(d == 32'h00200001, "R3 version write ignored", 64'(d), 64'h00200001);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e;
    do_reset();
    tbl_wr(31, 32'hCAFE0001); tbl_rd(31, d);
    check(d == 32'hCAFE0001, "R4 index 31 mapped", 64'(d), 64'hCAFE0001);
    wr(12'h800, 32); rd(12'h810, d, e);
    check(d == 32'hFFFFFFFF && e, "R4 read beyond table", {31'd0, e, d}, {31'd0, 1'b1, 32'hFFFFFFFF});
    wr_err(12'h810, 32'h0, e); check(e, "R4 write beyond table err", 64'(e), 1);
    tbl_rd(31, d); check(d == 32'hCAFE0001, "R4 write beyond table ignored", 64'(d), 64'hCAFE0001);
    rd(12'h820, d, e); check(e, "R4 undecoded offset", 64'(e), 1);
  endtask

  task automatic t_fire();
    do_reset();
    tbl_wr(16, 32'h0000A002);
    @(negedge clk); irq_in[0] = 1; @(negedge clk);
    check(pend == 8'h04, "R5 pend bit", 64'(pend), 64'h04);
    expect_msg(64'hFFFFFFFF_FFFA0000, 32'h02000000, "R5 msg default dest");
    tbl_wr(19, 32'h12340000); tbl_wr(18, 32'h0000A02B);
    @(negedge clk); irq_in[1] = 1;
    expect_msg(64'hFFFFFFFF_F3412000, 32'h2B000000, "R5 msg custom dest");
    check(pend == 8'h0C, "R5 pend two bits", 64'(pend), 64'h0C);
    expect_none("R7 held input no resend");
    @(negedge clk); irq_in[1] = 0; @(negedge clk);
    check(pend == 8'h04, "R7 deassert clears", 64'(pend), 64'h04);
    irq_in[1] = 1;
    expect_msg(64'hFFFFFFFF_F3412000, 32'h2B000000, "R7 re-rise resends");
  endtask

  task automatic t_mask();
    do_reset();
    @(negedge clk); irq_in[2] = 1;
    expect_none("R6 masked no msg");
    check(pend == 0, "R6 masked pend", 64'(pend), 0);
    irq_in[2] = 0;
    tbl_wr(22, 32'h0000A004);
    @(negedge clk); irq_in[3] = 1;
    expect_msg(64'hFFFFFFFF_FFFA0000, 32'h04000000, "R6 setup shared bit");
    check(pend == 8'h10, "R6 shared bit set", 64'(pend), 64'h10);
    @(negedge clk); irq_in[2] = 1; @(negedge clk);
    check(pend == 8'h00, "R6 masked rise clears", 64'(pend), 0);
  endtask

  task automatic t_eoi();
    do_reset();
    tbl_wr(16, 32'h0000A008);
    tbl_wr(18, 32'h0000A003);
    @(negedge clk); irq_in[0] = 1; irq_in[1] = 1;
    expect_msg(64'hFFFFFFFF_FFFA0000, 32'h08000000, "R8 setup a");
    expect_msg(64'hFFFFFFFF_FFFA0000, 32'h03000000, "R8 setup b");
    check(pend == 8'h09, "R8 before eoi", 64'(pend), 64'h09);
    wr(12'h840, 32'h00000011); @(negedge clk);
    check(pend == 8'h09, "R8 non-matching eoi", 64'(pend), 64'h09);
    wr(12'h840, 32'h00000048); @(negedge clk);
    check(pend == 8'h08, "R8 eoi clears index 0", 64'(pend), 64'h08);
  endtask

  task automatic t_queue();
    do_reset();
    tbl_wr(24, 32'h0000A016); tbl_wr(26, 32'h0000A017);
    @(negedge clk); irq_in[5] = 1; irq_in[4] = 1;
    for (int n = 0; n < 4; n++) @(negedge clk);
    check(msg_valid && msg_data == 32'h16000000, "R9 lowest first held", 64'(msg_data), 64'h16000000);
    expect_msg(64'hFFFFFFFF_FFFA0000, 32'h16000000, "R9 first");
    expect_msg(64'hFFFFFFFF_FFFA0000, 32'h17000000, "R9 second");
    expect_none("R9 nothing more");
  endtask

  task automatic t_already();
    do_reset();
    tbl_wr(28, 32'h0000A00D); tbl_wr(30, 32'h0000A015);
    @(negedge clk); irq_in[6] = 1;
    expect_msg(64'hFFFFFFFF_FFFA0000, 32'h0D000000, "R10 first");
    @(negedge clk); irq_in[7] = 1;
    expect_none("R10 already pending no msg");
    check(pend == 8'h20, "R10 bit stays", 64'(pend), 64'h20);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_window(); t_unmapped(); t_fire();
        t_mask(); t_eoi(); t_queue(); t_already();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule